// File: doc/BRIEF.md
# Hash Message Padding Unit

This block sits between a message source and a hash compression core. The message arrives as 32-bit words over a valid/ready handshake, and the last word is marked with an end strobe and a count of the bits in it that belong to the message. The unit passes the message words straight through. It places the single marker bit right after the last message bit and clears any unused bits below it. It then adds zero words and a 64-bit bit-length field, so that the core always receives whole 512-bit blocks of sixteen words.

Every outgoing word carries two flags. The first marks the sixteenth word of a block. The second marks the very last word of the padded message. When the marker bit falls into either of the last two words of a block, there is no room left for the length. The unit then zero-fills that block and emits one more block made of padding and the length. While padding and length words are being emitted, the unit does not accept input.

Bit order inside a word is MSB-first, so message bit 0 of a word is bit 31. A message holds at least one bit.

Top module: `hash_pad_unit`

## Requirements
- R1: Every word accepted before the final one is emitted unchanged and in arrival order, and `in_ready` equals `out_ready` while message words are being accepted.
- R2: For a final word with bit count k in 1..31, the emitted word keeps bits 31 down to 32-k, has bit 31-k set to 1, and has all lower bits 0. A count of 0 means all 32 bits are valid: that word is emitted unchanged and is followed by the word 0x80000000.
- R3: Blocks are 16 words long. `out_blk_end` is 1 on word positions 15 of each block and 0 elsewhere. After the marker bit, zero words fill the block up to position 13.
- R4: Positions 14 and 15 of the final block carry the message length in bits, computed as 32*(words-1)+k with k=32 when the count is 0. Position 14 holds bits 63:32 and position 15 holds bits 31:0.
- R5: If the marker bit is at position 14 or 15, the rest of that block is zeros. One more block follows, with zeros in positions 0..13 and the length in positions 14 and 15.
- R6: From the cycle after the final word is accepted until the last length word is taken, `in_ready` is 0, and input offered in that window has no effect on the output.
- R7: `out_msg_end` is 1 only on the low length word, and it always coincides with `out_blk_end`.
- R8: While a padding or length word is stalled by `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged.
- R9: After reset, and after each message completes, the unit accepts a new message starting at block position 0 with a bit count of zero. With `in_valid` low after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Message word offered |
| in_ready | output | 1 | Message word taken this cycle when valid |
| in_data | input | 32 | Message word, MSB-first |
| in_end | input | 1 | Offered word is the final word of the message |
| in_nbits | input | 5 | Valid bits in the final word; 0 means 32 |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Message, padding or length word |
| out_blk_end | output | 1 | Word is position 15 of a block |
| out_msg_end | output | 1 | Word is the last word of the padded message |

## Verification
The bench builds the unit with its default parameters: 32-bit words, 16-word blocks and a 64-bit length. Under these values every marker position from 0 to 15 can be reached with short messages. That includes positions 13, 14 and 15, where the choice between a direct length field and an extra block is made, as well as a full final word whose marker falls into the next block. Only the low length word can become non-zero within a run of this size, so the high word is checked at zero.

// File: rtl/hpu_pkg.sv
// Package: shared definitions for the hash message padding unit.
// Assumes: one encoding of the sequencer phase is shared by all submodules
// and by the bound checker.
package hpu_pkg;

    // Output phase of the padding unit
    typedef enum logic [2:0] {
        PH_MSG  = 3'd0,   // message words pass through
        PH_MARK = 3'd1,   // stand-alone marker word after a full final word
        PH_ZERO = 3'd2,   // zero fill
        PH_LHI  = 3'd3,   // length bits 63:32
        PH_LLO  = 3'd4    // length bits 31:0
    } hpu_phase_e;

endpackage

// File: rtl/hpu_shaper.sv
// Module: hpu_shaper
// Shapes the final message word. The top nbits bits are kept (MSB-first),
// the next lower bit is set as the padding marker, and the rest is cleared.
// Assumes: nbits == 0 means a full word; in that case the word passes
// unchanged and the marker is placed by the sequencer in a separate word.
module hpu_shaper #(
    parameter int WORD_W = 32,
    parameter int NB_W   = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [NB_W-1:0]   nbits_i,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [WORD_W-1:0] ALL_ONES = '1;
    localparam logic [WORD_W-1:0] TOP_BIT  = {1'b1, {(WORD_W-1){1'b0}}};

    logic [WORD_W-1:0] keep_mask;
    logic [WORD_W-1:0] marker;

    // Build keep mask and marker position from the bit count
    always_comb begin
        keep_mask = ~(ALL_ONES >> nbits_i);
        marker    = TOP_BIT >> nbits_i;
        if (nbits_i == '0) begin
            word_o = word_i;
        end else begin
            word_o = (word_i & keep_mask) | marker;
        end
    end

endmodule

// File: rtl/hpu_len_ctr.sv
// Module: hpu_len_ctr
// Accumulates the message length in bits. A non-final word adds WORD_W;
// the final word adds its bit count (WORD_W when the count is zero).
// Assumes: clear and add never coincide; the count wraps silently past
// the top of its range.
module hpu_len_ctr #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 64,
    parameter int NB_W   = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_i,
    input  logic             last_i,
    input  logic [NB_W-1:0]  nbits_i,
    input  logic             clr_i,
    output logic [LEN_W-1:0] len_o
);

    localparam logic [LEN_W-1:0] FULL_INC = LEN_W'(WORD_W);

    logic [LEN_W-1:0] inc;

    // Choose the increment for the accepted word
    always_comb begin
        if (last_i && (nbits_i != '0)) begin
            inc = LEN_W'(nbits_i);
        end else begin
            inc = FULL_INC;
        end
    end

    // Length register: clear at message end, add per accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_o <= '0;
        end else if (clr_i) begin
            len_o <= '0;
        end else if (add_i) begin
            len_o <= len_o + inc;
        end
    end

endmodule

// File: rtl/hpu_seq.sv
// Module: hpu_seq
// Tracks the word position inside the current block and the output phase.
// It decides whether the length fits the block that holds the marker or
// whether one extra block is needed.
// Assumes: positions advance only on an output handshake; in the message
// phase an input handshake and an output handshake are the same event.
module hpu_seq
    import hpu_pkg::*;
#(
    parameter int BLK_WORDS = 16,
    parameter int POS_W     = $clog2(BLK_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_fire_i,
    input  logic             in_end_i,
    input  logic             in_full_i,
    output hpu_phase_e       phase_o,
    output logic [POS_W-1:0] pos_o,
    output logic             pad_active_o
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK_WORDS - 1);
    localparam logic [POS_W-1:0] POS_LHI  = POS_W'(BLK_WORDS - 2);
    localparam logic [POS_W-1:0] POS_PRE  = POS_W'(BLK_WORDS - 3);

    hpu_phase_e       phase_q, phase_d;
    logic [POS_W-1:0] pos_q, pos_nxt;
    logic             extra_q, extra_d;

    // Position that follows the current one, wrapping at block end
    always_comb begin
        if (pos_q == POS_LAST) begin
            pos_nxt = '0;
        end else begin
            pos_nxt = pos_q + 1'b1;
        end
    end

    // Next phase and extra-block flag, evaluated per output handshake
    always_comb begin
        phase_d = phase_q;
        extra_d = extra_q;
        if (out_fire_i) begin
            unique case (phase_q)
                PH_MSG: begin
                    if (in_end_i) begin
                        if (in_full_i) begin
                            phase_d = PH_MARK;
                        end else if (pos_q == POS_PRE) begin
                            phase_d = PH_LHI;
                        end else begin
                            phase_d = PH_ZERO;
                            extra_d = (pos_q == POS_LHI);
                        end
                    end
                end
                PH_MARK: begin
                    if (pos_q == POS_PRE) begin
                        phase_d = PH_LHI;
                    end else begin
                        phase_d = PH_ZERO;
                        extra_d = (pos_q == POS_LHI);
                    end
                end
                PH_ZERO: begin
                    if (pos_q == POS_LAST) begin
                        extra_d = 1'b0;
                    end
                    if ((pos_nxt == POS_LHI) && !extra_d) begin
                        phase_d = PH_LHI;
                    end
                end
                PH_LHI: begin
                    phase_d = PH_LLO;
                end
                PH_LLO: begin
                    phase_d = PH_MSG;
                    extra_d = 1'b0;
                end
                default: begin
                    phase_d = PH_MSG;
                    extra_d = 1'b0;
                end
            endcase
        end
    end

    // State registers: phase, block position, extra-block flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_MSG;
            pos_q   <= '0;
            extra_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            extra_q <= extra_d;
            if (out_fire_i) begin
                pos_q <= pos_nxt;
            end
        end
    end

    assign phase_o      = phase_q;
    assign pos_o        = pos_q;
    assign pad_active_o = (phase_q != PH_MSG);

endmodule

// File: rtl/hash_pad_unit.sv
// Module: hash_pad_unit
// Turns a word stream with an end strobe and a final bit count into whole
// padded blocks: marker bit, zero fill, and a 64-bit length at the block end.
// Message words pass through combinationally. Padding and length words
// are generated locally while the input is held off.
// Assumes: LEN_W is exactly two words; each message has at least one bit.
module hash_pad_unit
    import hpu_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16,
    parameter int LEN_W     = 64,
    parameter int NB_W      = $clog2(WORD_W),
    parameter int POS_W     = $clog2(BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_end,
    input  logic [NB_W-1:0]   in_nbits,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_blk_end,
    output logic              out_msg_end
);

    localparam logic [WORD_W-1:0] MARK_WORD = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(BLK_WORDS - 1);

    hpu_phase_e        phase;
    logic [POS_W-1:0]  pos;
    logic              pad_active;
    logic [WORD_W-1:0] shaped;
    logic [LEN_W-1:0]  len;
    logic              in_fire;
    logic              out_fire;

    hpu_shaper #(.WORD_W(WORD_W), .NB_W(NB_W)) u_shaper (
        .word_i  (in_data),
        .nbits_i (in_nbits),
        .word_o  (shaped)
    );

    hpu_len_ctr #(.WORD_W(WORD_W), .LEN_W(LEN_W), .NB_W(NB_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_i   (in_fire),
        .last_i  (in_end),
        .nbits_i (in_nbits),
        .clr_i   (out_fire && (phase == PH_LLO)),
        .len_o   (len)
    );

    hpu_seq #(.BLK_WORDS(BLK_WORDS), .POS_W(POS_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .out_fire_i   (out_fire),
        .in_end_i     (in_end),
        .in_full_i    (in_nbits == '0),
        .phase_o      (phase),
        .pos_o        (pos),
        .pad_active_o (pad_active)
    );

    // Output word and handshake selection by phase
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_data  = '0;
        unique case (phase)
            PH_MSG: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_end ? shaped : in_data;
            end
            PH_MARK: out_data = MARK_WORD;
            PH_ZERO: out_data = '0;
            PH_LHI:  out_data = len[LEN_W-1:WORD_W];
            PH_LLO:  out_data = len[WORD_W-1:0];
            default: out_valid = 1'b0;
        endcase
    end

    assign in_fire     = in_valid && in_ready;
    assign out_fire    = out_valid && out_ready;
    assign out_blk_end = out_valid && (pos == POS_LAST);
    assign out_msg_end = out_valid && (phase == PH_LLO);

endmodule

// File: rtl/hpu_checker.sv
// Module: hpu_checker
// Protocol properties of the padding unit, attached by bind.
// Assumes: default parameters or any where BLK_WORDS is a power of two.
module hpu_checker #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16,
    parameter int POS_W     = $clog2(BLK_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_end,
    input logic [4:0]        in_nbits,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_blk_end,
    input logic              out_msg_end,
    input logic              pad_active
);

    localparam logic [WORD_W-1:0] MARK_WORD = {1'b1, {(WORD_W-1){1'b0}}};

    logic [POS_W-1:0] beat_cnt;

    // Independent count of output beats since the last block end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (out_valid && out_ready) begin
            beat_cnt <= out_blk_end ? '0 : beat_cnt + 1'b1;
        end
    end

    AST_BLK_END_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (out_blk_end == (beat_cnt == POS_W'(BLK_WORDS - 1)))); // R3

    AST_MSG_END_ON_BLK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_msg_end) |-> out_blk_end); // R7

    AST_FULL_WORD_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_end && (in_nbits == 5'd0)) |=> (out_valid && (out_data == MARK_WORD))); // R2

    AST_STALL_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_end) |=> !in_ready); // R6

    AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_active && out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_blk_end))); // R8

    AST_RETURN_TO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_msg_end) |=> !pad_active); // R9

endmodule

bind hash_pad_unit hpu_checker #(
    .WORD_W    (WORD_W),
    .BLK_WORDS (BLK_WORDS),
    .POS_W     (POS_W)
) u_hpu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_end      (in_end),
    .in_nbits    (in_nbits),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_blk_end (out_blk_end),
    .out_msg_end (out_msg_end),
    .pad_active  (pad_active)
);

// File: tb/hash_pad_unit_test.sv
module hash_pad_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_end = 1'b0;
    logic [4:0]  in_nbits = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_blk_end;
    logic        out_msg_end;

    int vec_cnt = 0;
    int err_cnt = 0;
    bit done = 1'b0;
    bit rdy_random = 1'b0;

    logic [31:0] exp_data[$];
    logic        exp_blk[$];
    logic        exp_msg[$];
    string       exp_tag[$];
    int          exp_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hash_pad_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_end      (in_end),
        .in_nbits    (in_nbits),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_blk_end (out_blk_end),
        .out_msg_end (out_msg_end)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] shape_word(input logic [31:0] w, input int k);
        return (w & ~(32'hFFFF_FFFF >> k)) | (32'h8000_0000 >> k);
    endfunction

    task automatic push_exp(input logic [31:0] d, input string tag, input bit last);
        exp_data.push_back(d);
        exp_blk.push_back((exp_idx % 16) == 15);
        exp_msg.push_back(last);
        exp_tag.push_back(tag);
        exp_idx++;
    endtask

    // Send one message of n words with final bit count k; optional gaps and junk
    task automatic send_msg(input int n, input int k, input bit gaps, input bit junk);
        logic [31:0] words[$];
        longint unsigned bits;
        string ztag;
        exp_idx = 0;
        for (int i = 0; i < n; i++) words.push_back($urandom);
        for (int i = 0; i < n; i++) begin
            if (i < n - 1) push_exp(words[i], "R1", 1'b0);
            else if (k == 0) begin
                push_exp(words[i], "R2", 1'b0);
                push_exp(32'h8000_0000, "R2", 1'b0);
            end else push_exp(shape_word(words[i], k), "R2", 1'b0);
        end
        ztag = ((exp_idx - 1) % 16 >= 14) ? "R5" : "R3";
        while ((exp_idx % 16) != 14) push_exp(32'h0, ztag, 1'b0);
        bits = 64'(32 * (n - 1)) + 64'((k == 0) ? 32 : k);
        push_exp(bits[63:32], "R4", 1'b0);
        push_exp(bits[31:0], "R4", 1'b1);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                in_valid = 1'b0;
                repeat ($urandom % 3) @(posedge clk);
                #1;
            end
            in_valid = 1'b1;
            in_data  = words[i];
            in_end   = (i == n - 1);
            in_nbits = (i == n - 1) ? 5'(k) : 5'($urandom);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
        end
        if (junk) begin
            in_valid = 1'b1;
            in_data  = $urandom;
            in_end   = 1'($urandom);
        end else begin
            in_valid = 1'b0;
        end
        @(negedge clk);
        while (exp_data.size() != 0) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_end   = 1'b0;
    endtask

    // Downstream ready: held high unless randomisation is enabled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = rdy_random ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    // Output monitor, sampled mid-cycle
    bit          pad_phase = 1'b0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (pad_phase) begin
                    check(in_ready == 1'b0, "R6 in_ready during padding", 64'(in_ready), 64'd0);
                    if (prev_stall) begin
                        check(out_valid && (out_data == prev_data), "R8 stalled word held",
                              {31'd0, out_valid, out_data}, {31'd0, 1'b1, prev_data});
                    end
                end else if (in_valid && out_valid) begin
                    check(in_ready == out_ready, "R1 ready follows downstream", 64'(in_ready), 64'(out_ready));
                end
                prev_stall = pad_phase && out_valid && !out_ready;
                prev_data  = out_data;
                if (out_valid && out_ready) begin
                    if (exp_data.size() == 0) begin
                        check(1'b0, "R6 unexpected output word", 64'(out_data), 64'd0);
                    end else begin
                        check(out_data == exp_data[0], exp_tag[0], 64'(out_data), 64'(exp_data[0]));
                        check(out_blk_end == exp_blk[0], "R3 block end flag", 64'(out_blk_end), 64'(exp_blk[0]));
                        check(out_msg_end == exp_msg[0], "R7 message end flag", 64'(out_msg_end), 64'(exp_msg[0]));
                        if (out_msg_end) pad_phase = 1'b0;
                        void'(exp_data.pop_front());
                        void'(exp_blk.pop_front());
                        void'(exp_msg.pop_front());
                        void'(exp_tag.pop_front());
                    end
                end
                if (in_valid && in_ready && in_end) pad_phase = 1'b1;
            end
        end
    end

    // Watchdog: an expired run is a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vec_cnt++;
            err_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 idle output after reset", 64'(out_valid), 64'd0);
        check(in_ready == out_ready, "R9 ready after reset", 64'(in_ready), 64'(out_ready));
        @(posedge clk);
        #1;
        // Directed corner cases: marker positions around the length field
        send_msg(1, 1, 1'b0, 1'b0);    // marker bit 30 of word 0
        send_msg(13, 0, 1'b0, 1'b1);   // marker word at position 13
        send_msg(14, 5, 1'b0, 1'b0);   // marker inside position 13
        send_msg(15, 8, 1'b0, 1'b1);   // marker at position 14: extra block (R5)
        send_msg(16, 31, 1'b0, 1'b0);  // marker at position 15: extra block (R5)
        send_msg(14, 0, 1'b0, 1'b1);   // marker word at position 14 (R5)
        send_msg(16, 0, 1'b0, 1'b0);   // marker word at position 0 of next block
        send_msg(2, 16, 1'b0, 1'b0);
        rdy_random = 1'b1;
        send_msg(15, 0, 1'b1, 1'b1);   // marker word at position 15 with stalls (R5, R8)
        // Constrained random messages
        for (int m = 0; m < 40; m++) begin
            send_msg(1 + ($urandom % 40), $urandom % 32, 1'($urandom), 1'($urandom));
        end
        repeat (4) @(negedge clk);
        check(exp_data.size() == 0, "R4 all expected words emitted", 64'(exp_data.size()), 64'd0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

endmodule